// File: doc/BRIEF.md
# Fast Ethernet Receive Symbol Checker

This block sits after the clock-recovery and descrambling stages of a 100 Mb/s receiver. It takes the recovered 5-bit code groups and turns them into the reduced-pin-count receive signals that a MAC controller samples. It runs from the 50 MHz reference clock. A code group arrives with a single-cycle strobe, one group every two reference cycles. For each group the block sends one 4-bit nibble as two 2-bit symbols, so the output bus runs at the full reference rate.

A frame opens when the start delimiter pair is seen. Data groups are then mapped to nibbles and flagged valid. The end-of-stream pair closes the frame. Any other group inside a frame raises the receive-error flag. A broken start delimiter is handled on its own path: the block puts out a fixed error nibble and keeps data-valid low. It holds that state until the line goes idle, then starts hunting for a delimiter again. All outputs are launched on the falling edge of the reference clock, so a controller that samples on the rising edge has half a period of setup and half a period of hold.

Top module: `rx_symbol_checker`

## Requirements
- R1: While reset is asserted, and after release until the first code group has been taken, `rx_dv` and `rx_er` are 0 and `rx_sym` is 00.
- R2: Inside a frame, each data group drives `rx_dv`=1 and `rx_er`=0 with the nibble below. The encoding is 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101.
- R3: A group taken on the rising edge where `cg_strobe` is high drives its nibble's low two bits on `rx_sym` from the next falling edge, and its high two bits from the falling edge after that. Strobes are at least two cycles apart.
- R4: While hunting, the start group 11000 produces idle output. If the next group is 10001, the frame opens: `rx_dv` rises and that group is sent as nibble 0101.
- R5: If the group after 11000 is anything other than 10001, that group and every later group drive `rx_er`=1, `rx_dv`=0 and nibble 1110, which goes out as symbols 10 then 11. An idle group 11111 ends this state, gives idle output for that group, and resumes hunting.
- R6: Inside a frame, a group that is neither a data group nor 01101 drives `rx_er`=1 with `rx_dv`=1 for that group only. A following data group clears `rx_er`.
- R7: Inside a frame, 01101 followed by 00111 drives `rx_dv`=0, `rx_er`=0 and `rx_sym`=00 from the 01101 group onward, and the block resumes hunting.
- R8: If 01101 inside a frame is followed by a group other than 00111, that group drives `rx_er`=1 and `rx_dv`=1, and the frame continues.
- R9: While hunting, any group other than 11000 has no effect: the outputs stay idle.
- R10: `rx_dv` and `rx_er` keep the same value across both symbols of a group, and change only on falling edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cg_strobe | input | 1 | High for one cycle when `cg_data` holds a new code group |
| cg_data | input | 5 | Recovered 5-bit code group |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |
| rx_sym | output | 2 | Receive symbol, low half of the nibble first |

## Verification
A group strobed at rising edge t has its first symbol on the bus from the falling edge at t+0.5. The bench samples that symbol two time units after rising edge t+1, and the second symbol two units after edge t+2, well away from the falling edges where the outputs move. For every group the driver queues two expected symbols. The monitor records whether a strobe was present at each rising edge and pops the queue exactly one and two cycles later, so each comparison lands in the middle of the symbol it checks. During error groups inside a frame the symbol value may be arbitrary, so only the flags are compared there. The error pattern of a bad start delimiter is compared bit for bit.

// File: rtl/rx_symbol_pkg.sv
package rx_symbol_pkg;

  localparam logic [4:0] CG_START_A = 5'b11000;
  localparam logic [4:0] CG_START_B = 5'b10001;
  localparam logic [4:0] CG_END_A   = 5'b01101;
  localparam logic [4:0] CG_END_B   = 5'b00111;
  localparam logic [4:0] CG_IDLE    = 5'b11111;

  localparam logic [3:0] NIB_SSD_ERR  = 4'hE;
  localparam logic [3:0] NIB_PREAMBLE = 4'h5;

  typedef enum logic [2:0] {
    CLS_DATA,
    CLS_IDLE,
    CLS_START_A,
    CLS_START_B,
    CLS_END_A,
    CLS_END_B,
    CLS_BAD
  } cg_class_e;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_SAW_START,
    ST_FRAME,
    ST_SAW_END,
    ST_BAD_SSD
  } rx_state_e;

endpackage

// File: rtl/rx_cg_decode.sv
module rx_cg_decode
  import rx_symbol_pkg::*;
#(
  parameter int CG_W  = 5,
  parameter int NIB_W = 4
) (
  input  logic [CG_W-1:0]  cg_i,
  output cg_class_e        cls_o,
  output logic [NIB_W-1:0] nib_o
);

  always_comb begin
    cls_o = CLS_DATA;
    nib_o = '0;
    case (cg_i)
      5'b11110: nib_o = NIB_W'(4'h0);
      5'b01001: nib_o = NIB_W'(4'h1);
      5'b10100: nib_o = NIB_W'(4'h2);
      5'b10101: nib_o = NIB_W'(4'h3);
      5'b01010: nib_o = NIB_W'(4'h4);
      5'b01011: nib_o = NIB_W'(4'h5);
      5'b01110: nib_o = NIB_W'(4'h6);
      5'b01111: nib_o = NIB_W'(4'h7);
      5'b10010: nib_o = NIB_W'(4'h8);
      5'b10011: nib_o = NIB_W'(4'h9);
      5'b10110: nib_o = NIB_W'(4'hA);
      5'b10111: nib_o = NIB_W'(4'hB);
      5'b11010: nib_o = NIB_W'(4'hC);
      5'b11011: nib_o = NIB_W'(4'hD);
      5'b11100: nib_o = NIB_W'(4'hE);
      5'b11101: nib_o = NIB_W'(4'hF);
      CG_IDLE:    cls_o = CLS_IDLE;
      CG_START_A: cls_o = CLS_START_A;
      CG_START_B: cls_o = CLS_START_B;
      CG_END_A:   cls_o = CLS_END_A;
      CG_END_B:   cls_o = CLS_END_B;
      default:    cls_o = CLS_BAD;
    endcase
  end

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import rx_symbol_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_i,
  input  cg_class_e        cls_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic             dv_o,
  output logic             er_o,
  output logic [NIB_W-1:0] nib_o,
  output logic             load_o
);

  rx_state_e        st_q, st_n;
  logic             dv_q, dv_n;
  logic             er_q, er_n;
  logic [NIB_W-1:0] nib_q, nib_n;
  logic             load_q;

  always_comb begin
    st_n  = st_q;
    dv_n  = dv_q;
    er_n  = er_q;
    nib_n = nib_q;
    if (strobe_i) begin
      case (st_q)
        ST_HUNT: begin
          dv_n  = 1'b0;
          er_n  = 1'b0;
          nib_n = '0;
          if (cls_i == CLS_START_A) st_n = ST_SAW_START;
        end
        ST_SAW_START: begin
          if (cls_i == CLS_START_B) begin
            st_n  = ST_FRAME;
            dv_n  = 1'b1;
            er_n  = 1'b0;
            nib_n = NIB_W'(NIB_PREAMBLE);
          end else begin
            st_n  = ST_BAD_SSD;
            dv_n  = 1'b0;
            er_n  = 1'b1;
            nib_n = NIB_W'(NIB_SSD_ERR);
          end
        end
        ST_FRAME: begin
          if (cls_i == CLS_DATA) begin
            dv_n  = 1'b1;
            er_n  = 1'b0;
            nib_n = nib_i;
          end else if (cls_i == CLS_END_A) begin
            st_n  = ST_SAW_END;
            dv_n  = 1'b0;
            er_n  = 1'b0;
            nib_n = '0;
          end else begin
            dv_n  = 1'b1;
            er_n  = 1'b1;
            nib_n = '0;
          end
        end
        ST_SAW_END: begin
          if (cls_i == CLS_END_B) begin
            st_n  = ST_HUNT;
            dv_n  = 1'b0;
            er_n  = 1'b0;
            nib_n = '0;
          end else begin
            st_n  = ST_FRAME;
            dv_n  = 1'b1;
            er_n  = 1'b1;
            nib_n = '0;
          end
        end
        ST_BAD_SSD: begin
          if (cls_i == CLS_IDLE) begin
            st_n  = ST_HUNT;
            dv_n  = 1'b0;
            er_n  = 1'b0;
            nib_n = '0;
          end else begin
            dv_n  = 1'b0;
            er_n  = 1'b1;
            nib_n = NIB_W'(NIB_SSD_ERR);
          end
        end
        default: begin
          st_n  = ST_HUNT;
          dv_n  = 1'b0;
          er_n  = 1'b0;
          nib_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      dv_q   <= 1'b0;
      er_q   <= 1'b0;
      nib_q  <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= strobe_i;
      if (strobe_i) begin
        st_q  <= st_n;
        dv_q  <= dv_n;
        er_q  <= er_n;
        nib_q <= nib_n;
      end
    end
  end

  assign dv_o   = dv_q;
  assign er_o   = er_q;
  assign nib_o  = nib_q;
  assign load_o = load_q;

  AST_SSD_ERR_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && st_q == ST_SAW_START && cls_i != CLS_START_B)
      |=> (er_q && !dv_q && nib_q == NIB_W'(NIB_SSD_ERR))); // R5

  AST_DV_RISE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dv_q) |-> ($past(st_q) == ST_SAW_START || $past(st_q) == ST_SAW_END)); // R4

  AST_IDLE_ZERO_NIB: assert property (@(posedge clk) disable iff (!rst_n)
    (!dv_q && !er_q) |-> (nib_q == '0)); // R7

  AST_HUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HUNT) |-> (!er_q && !dv_q)); // R9

  AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i |=> !strobe_i); // R3

endmodule

// File: rtl/rx_sym_serializer.sv
module rx_sym_serializer #(
  parameter int NIB_W = 4,
  parameter int SYM_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             dv_i,
  input  logic             er_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic             dv_o,
  output logic             er_o,
  output logic [SYM_W-1:0] sym_o
);

  logic             dv_q, dv_n;
  logic             er_q, er_n;
  logic [SYM_W-1:0] sym_q, sym_n;
  logic [NIB_W-1:0] shr_q, shr_n;

  always_comb begin
    dv_n  = dv_q;
    er_n  = er_q;
    sym_n = shr_q[SYM_W-1:0];
    shr_n = shr_q >> SYM_W;
    if (load_i) begin
      dv_n  = dv_i;
      er_n  = er_i;
      sym_n = nib_i[SYM_W-1:0];
      shr_n = nib_i >> SYM_W;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q  <= 1'b0;
      er_q  <= 1'b0;
      sym_q <= '0;
      shr_q <= '0;
    end else begin
      dv_q  <= dv_n;
      er_q  <= er_n;
      sym_q <= sym_n;
      shr_q <= shr_n;
    end
  end

  assign dv_o  = dv_q;
  assign er_o  = er_q;
  assign sym_o = sym_q;

  AST_FLAGS_HOLD_MID_NIBBLE: assert property (@(negedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(dv_q) && $stable(er_q))); // R10

endmodule

// File: rtl/rx_symbol_checker.sv
module rx_symbol_checker
  import rx_symbol_pkg::*;
#(
  parameter int CG_W  = 5,
  parameter int NIB_W = 4,
  parameter int SYM_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cg_strobe,
  input  logic [CG_W-1:0]  cg_data,
  output logic             rx_dv,
  output logic             rx_er,
  output logic [SYM_W-1:0] rx_sym
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  cg_class_e              dec_cls;
  logic [NIB_W-1:0]       dec_nib;
  logic                   fsm_dv;
  logic                   fsm_er;
  logic [NIB_W-1:0]       fsm_nib;
  logic                   fsm_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  rx_cg_decode #(.CG_W(CG_W), .NIB_W(NIB_W)) u_decode (
    .cg_i  (cg_data),
    .cls_o (dec_cls),
    .nib_o (dec_nib)
  );

  rx_frame_fsm #(.NIB_W(NIB_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .strobe_i (cg_strobe),
    .cls_i    (dec_cls),
    .nib_i    (dec_nib),
    .dv_o     (fsm_dv),
    .er_o     (fsm_er),
    .nib_o    (fsm_nib),
    .load_o   (fsm_load)
  );

  rx_sym_serializer #(.NIB_W(NIB_W), .SYM_W(SYM_W)) u_ser (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (fsm_load),
    .dv_i   (fsm_dv),
    .er_i   (fsm_er),
    .nib_i  (fsm_nib),
    .dv_o   (rx_dv),
    .er_o   (rx_er),
    .sym_o  (rx_sym)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_int_n |-> (!rx_dv && !rx_er && rx_sym == '0)); // R1

endmodule

// File: tb/rx_symbol_checker_bench.sv
module rx_symbol_checker_bench;

  localparam int CLK_PERIOD = 20;

  typedef struct {
    logic       dv;
    logic       er;
    logic [1:0] sym;
    logic       chk_sym;
    string      req;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic       cg_strobe;
  logic [4:0] cg_data;
  logic       rx_dv;
  logic       rx_er;
  logic [1:0] rx_sym;

  exp_t exp_q[$];
  int   n_checks;
  int   n_fails;
  bit   finished;

  rx_symbol_checker u_rx_symbol_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cg_strobe (cg_strobe),
    .cg_data   (cg_data),
    .rx_dv     (rx_dv),
    .rx_er     (rx_er),
    .rx_sym    (rx_sym)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: enc = 5'b11110; 4'h1: enc = 5'b01001;
      4'h2: enc = 5'b10100; 4'h3: enc = 5'b10101;
      4'h4: enc = 5'b01010; 4'h5: enc = 5'b01011;
      4'h6: enc = 5'b01110; 4'h7: enc = 5'b01111;
      4'h8: enc = 5'b10010; 4'h9: enc = 5'b10011;
      4'hA: enc = 5'b10110; 4'hB: enc = 5'b10111;
      4'hC: enc = 5'b11010; 4'hD: enc = 5'b11011;
      4'hE: enc = 5'b11100; default: enc = 5'b11101;
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic [4:0] cg, input logic dv, input logic er,
                      input logic [3:0] nib, input logic chk, input string req);
    exp_t a;
    exp_t b;
    @(negedge clk);
    cg_data   = cg;
    cg_strobe = 1'b1;
    a.dv = dv; a.er = er; a.sym = nib[1:0]; a.chk_sym = chk; a.req = req;
    b.dv = dv; b.er = er; b.sym = nib[3:2]; b.chk_sym = chk; b.req = {req, "/R10"};
    exp_q.push_back(a);
    exp_q.push_back(b);
    @(negedge clk);
    cg_strobe = 1'b0;
  endtask

  task automatic idle_out(input string req);
    send(5'b11111, 1'b0, 1'b0, 4'h0, 1'b1, req);
  endtask

  // monitor: a group strobed at edge t is compared at t+1 and t+2
  initial begin
    logic p1;
    logic p2;
    logic st;
    exp_t e;
    p1 = 1'b0;
    p2 = 1'b0;
    forever begin
      @(posedge clk);
      st = cg_strobe;
      #2;
      if (p1 || p2) begin
        if (exp_q.size() == 0) begin
          check("R3 queue empty", 4'h1, 4'h0);
        end else begin
          e = exp_q.pop_front();
          if (e.chk_sym)
            check(e.req, {rx_dv, rx_er, rx_sym}, {e.dv, e.er, e.sym});
          else
            check(e.req, {2'b00, rx_dv, rx_er}, {2'b00, e.dv, e.er});
        end
      end
      p2 = p1;
      p1 = st;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    n_checks  = 0;
    n_fails   = 0;
    finished  = 1'b0;
    rst_n     = 1'b0;
    cg_strobe = 1'b0;
    cg_data   = 5'b11111;
    #(CLK_PERIOD * 3 + 3);
    check("R1 during reset", {rx_dv, rx_er, rx_sym}, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #3;
    check("R1 after release", {rx_dv, rx_er, rx_sym}, 4'b0000);

    // R9: groups other than the start group are ignored while hunting
    idle_out("R9 idle");
    send(enc(4'h3), 1'b0, 1'b0, 4'h0, 1'b1, "R9 data while hunting");
    send(5'b10001, 1'b0, 1'b0, 4'h0, 1'b1, "R9 lone second start group");
    send(5'b00000, 1'b0, 1'b0, 4'h0, 1'b1, "R9 illegal while hunting");
    idle_out("R9 idle");

    // R4, R2, R7: full frame with all sixteen nibbles
    send(5'b11000, 1'b0, 1'b0, 4'h0, 1'b1, "R4 first start group");
    send(5'b10001, 1'b1, 1'b0, 4'h5, 1'b1, "R4 dv rises");
    for (int i = 0; i < 16; i++)
      send(enc(4'(i)), 1'b1, 1'b0, 4'(i), 1'b1, "R2 data nibble R3 order");
    send(5'b01101, 1'b0, 1'b0, 4'h0, 1'b1, "R7 end group A");
    send(5'b00111, 1'b0, 1'b0, 4'h0, 1'b1, "R7 end group B");
    idle_out("R7 idle after frame");
    send(enc(4'h9), 1'b0, 1'b0, 4'h0, 1'b1, "R7 R9 hunting after end");

    // R6: illegal group inside a frame
    send(5'b11000, 1'b0, 1'b0, 4'h0, 1'b1, "R4 start");
    send(5'b10001, 1'b1, 1'b0, 4'h5, 1'b1, "R4 open");
    send(enc(4'hA), 1'b1, 1'b0, 4'hA, 1'b1, "R2 data");
    send(5'b00000, 1'b1, 1'b1, 4'h0, 1'b0, "R6 illegal in frame");
    send(enc(4'h3), 1'b1, 1'b0, 4'h3, 1'b1, "R6 error cleared");
    send(5'b11111, 1'b1, 1'b1, 4'h0, 1'b0, "R6 idle in frame");
    send(5'b11000, 1'b1, 1'b1, 4'h0, 1'b0, "R6 start group in frame");
    send(enc(4'hC), 1'b1, 1'b0, 4'hC, 1'b1, "R6 error cleared again");
    send(5'b01101, 1'b0, 1'b0, 4'h0, 1'b1, "R7 end A");
    send(5'b00111, 1'b0, 1'b0, 4'h0, 1'b1, "R7 end B");
    idle_out("R7 idle");

    // R8: end group A not followed by end group B
    send(5'b11000, 1'b0, 1'b0, 4'h0, 1'b1, "R4 start");
    send(5'b10001, 1'b1, 1'b0, 4'h5, 1'b1, "R4 open");
    send(enc(4'h7), 1'b1, 1'b0, 4'h7, 1'b1, "R2 data");
    send(5'b01101, 1'b0, 1'b0, 4'h0, 1'b1, "R7 end A");
    send(enc(4'h9), 1'b1, 1'b1, 4'h0, 1'b0, "R8 broken end pair");
    send(enc(4'h1), 1'b1, 1'b0, 4'h1, 1'b1, "R8 frame continues");
    send(5'b01101, 1'b0, 1'b0, 4'h0, 1'b1, "R7 end A");
    send(5'b00111, 1'b0, 1'b0, 4'h0, 1'b1, "R7 end B");
    idle_out("R7 idle");

    // R5: bad start delimiter
    send(5'b11000, 1'b0, 1'b0, 4'h0, 1'b1, "R4 start");
    send(enc(4'h5), 1'b0, 1'b1, 4'hE, 1'b1, "R5 bad delimiter pattern");
    send(enc(4'h6), 1'b0, 1'b1, 4'hE, 1'b1, "R5 pattern held");
    send(5'b10001, 1'b0, 1'b1, 4'hE, 1'b1, "R5 held on second start group");
    idle_out("R5 idle ends bad state");
    send(enc(4'h2), 1'b0, 1'b0, 4'h0, 1'b1, "R5 R9 hunting resumed");
    send(5'b11000, 1'b0, 1'b0, 4'h0, 1'b1, "R5 start after recovery");
    send(5'b10001, 1'b1, 1'b0, 4'h5, 1'b1, "R5 open after recovery");
    send(enc(4'h2), 1'b1, 1'b0, 4'h2, 1'b1, "R2 data after recovery");
    send(5'b01101, 1'b0, 1'b0, 4'h0, 1'b1, "R7 end A");
    send(5'b00111, 1'b0, 1'b0, 4'h0, 1'b1, "R7 end B");

    // R5: start group followed by idle
    send(5'b11000, 1'b0, 1'b0, 4'h0, 1'b1, "R4 start");
    send(5'b11111, 1'b0, 1'b1, 4'hE, 1'b1, "R5 idle as second delimiter group");
    idle_out("R5 idle returns to hunting");
    idle_out("R9 idle");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) check("R3 leftover expectations", 4'(exp_q.size()), 4'h0);
    finish_run();
  end

endmodule